// File: doc/BRIEF.md
# ADC Conversion Timing Generator

This block paces an analog-to-digital converter from one fixed input clock. It divides the input clock by a selectable power of two to produce a one-cycle analog-clock enable pulse. It then counts those pulses to mark the start of each conversion slot for the channel sequencer downstream. A conversion takes six prescaled clocks for each step of a programmable core-time-unit count, plus one extra step.

Software controls the block through two 32-bit registers. A timing register holds the divider code and the core-time-unit count. A global configuration register holds an enable bit and two shutdown bits, one for the clock and one for power. Pulses appear only while the block is enabled and neither shutdown bit is set. Before it rewrites the timing register, software is expected to stop all four conversion slots of the sequencer. Any write to the timing register restarts both counters from zero, so the new pacing starts from a known phase.

Top module: `adc_tgen`

## Requirements
- R1: After reset both registers read as zero, and neither aclkEn nor slotStrobe is asserted.
- R2: The timing register is at select 0. Its divider code is held in bits 31:29 and its core-time-unit count in bits CTU_W-1:0 (7:0 by default). All other bits read as zero.
- R3: The configuration register is at select 1. Bit 31 is clock-down, bit 1 is power-down and bit 0 is enable. All other bits read as zero.
- R4: While running, aclkEn is high for one cycle in every D input cycles, with D = 4 << code for codes 0 to 5. The first pulse comes D cycles after the write that started the count.
- R5: Divider codes 6 and 7 give D = 128, the same as code 5.
- R6: slotStrobe is high only together with aclkEn, once every (ctu+1)*6 aclkEn pulses. The first strobe comes D*(ctu+1)*6 cycles after the start.
- R7: The block runs only when enable is 1 and both clock-down and power-down are 0. Otherwise neither output is asserted and both counters are held at zero, so pacing restarts from zero when the block runs again.
- R8: A write to the timing register clears both counters at that clock edge. This holds even in a cycle in which a pulse is due. Pacing then restarts exactly as in R4 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed input clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 timing, 1 configuration |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read target: 0 timing, 1 configuration |
| rdData | output | 32 | Read data of the selected register |
| aclkEn | output | 1 | One-cycle analog-clock enable pulse |
| slotStrobe | output | 1 | One-cycle conversion-slot start strobe |

## Verification
A write to the timing register can land in the same cycle in which the prescaler is at its terminal count and an aclkEn pulse is showing. The bench waits until it sees aclkEn high and drives the timing write in that same low phase. It then judges the outcome cycle by cycle: the pattern that follows must match a clean restart from zero, with the first pulse D cycles later and the first slot strobe D*(ctu+1)*6 cycles later. There must be no extra short interval left over from the old count.

// File: rtl/adc_tgen_pkg.sv
package adc_tgen_pkg;

  localparam int RegW       = 32;
  localparam int CodeW      = 3;
  localparam int CodeLsb    = 29;
  localparam int CfgClkDnBit = 31;
  localparam int CfgPwrDnBit = 1;
  localparam int CfgEnBit    = 0;
  localparam int StepsPerUnit = 6;

  localparam logic SelTimer = 1'b0;
  localparam logic SelCfg   = 1'b1;

  typedef struct packed {
    logic run;
    logic clear;
  } tgen_strobe_t;

endpackage

// File: rtl/adc_tgen_ctrl.sv
module adc_tgen_ctrl
  import adc_tgen_pkg::*;
#(
  parameter int CTU_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [RegW-1:0]  wrData,
  input  logic             rdSel,
  output logic [RegW-1:0]  rdData,
  output logic [CodeW-1:0] preCode,
  output logic [CTU_W-1:0] unitCount,
  output tgen_strobe_t     strobes
);

  logic cfgClkDown;
  logic cfgPwrDown;
  logic cfgEnable;
  logic unusedWrBits;

  assign unusedWrBits = ^{wrData[CodeLsb-1:CTU_W], wrData[CfgClkDnBit-1:CfgPwrDnBit+1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCode    <= '0;
      unitCount  <= '0;
      cfgClkDown <= 1'b0;
      cfgPwrDown <= 1'b0;
      cfgEnable  <= 1'b0;
    end else if (wrEn) begin
      if (wrSel == SelTimer) begin
        preCode   <= wrData[CodeLsb +: CodeW];
        unitCount <= wrData[CTU_W-1:0];
      end else begin
        cfgClkDown <= wrData[CfgClkDnBit];
        cfgPwrDown <= wrData[CfgPwrDnBit];
        cfgEnable  <= wrData[CfgEnBit];
      end
    end
  end

  always_comb begin
    strobes.run   = cfgEnable && !cfgClkDown && !cfgPwrDown;
    strobes.clear = wrEn && (wrSel == SelTimer);
  end

  always_comb begin
    rdData = '0;
    if (rdSel == SelTimer) begin
      rdData[CodeLsb +: CodeW] = preCode;
      rdData[CTU_W-1:0]        = unitCount;
    end else begin
      rdData[CfgClkDnBit] = cfgClkDown;
      rdData[CfgPwrDnBit] = cfgPwrDown;
      rdData[CfgEnBit]    = cfgEnable;
    end
  end

endmodule

// File: rtl/adc_tgen_datapath.sv
module adc_tgen_datapath
  import adc_tgen_pkg::*;
#(
  parameter int CTU_W     = 8,
  parameter int BASE_DIV  = 4,
  parameter int DIV_CODES = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  tgen_strobe_t     strobes,
  input  logic [CodeW-1:0] preCode,
  input  logic [CTU_W-1:0] unitCount,
  output logic             aclkEn,
  output logic             slotStrobe
);

  localparam int MaxDiv  = BASE_DIV << (DIV_CODES - 1);
  localparam int PreW    = $clog2(MaxDiv);
  localparam int MaxPer  = (1 << CTU_W) * StepsPerUnit;
  localparam int PerW    = $clog2(MaxPer);

  logic [PreW-1:0] preCnt;
  logic [PreW-1:0] preLim;
  logic [PerW-1:0] tuCnt;
  logic [PerW-1:0] tuLim;
  logic            preWrap;
  logic            tuWrap;

  always_comb begin
    preLim = PreW'(MaxDiv - 1);
    for (int k = 0; k < DIV_CODES; k++) begin
      if (int'(preCode) == k) preLim = PreW'((BASE_DIV << k) - 1);
    end
  end

  assign tuLim   = (PerW'(unitCount) + PerW'(1)) * PerW'(StepsPerUnit) - PerW'(1);
  assign preWrap = (preCnt == preLim);
  assign tuWrap  = (tuCnt == tuLim);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear || !strobes.run) begin
      preCnt <= '0;
      tuCnt  <= '0;
    end else if (preWrap) begin
      preCnt <= '0;
      tuCnt  <= tuWrap ? '0 : tuCnt + PerW'(1);
    end else begin
      preCnt <= preCnt + PreW'(1);
    end
  end

  assign aclkEn     = strobes.run && preWrap;
  assign slotStrobe = aclkEn && tuWrap;

endmodule

// File: rtl/adc_tgen.sv
module adc_tgen
  import adc_tgen_pkg::*;
#(
  parameter int CTU_W     = 8,
  parameter int BASE_DIV  = 4,
  parameter int DIV_CODES = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [31:0] wrData,
  input  logic        rdSel,
  output logic [31:0] rdData,
  output logic        aclkEn,
  output logic        slotStrobe
);

  tgen_strobe_t     strobes;
  logic [CodeW-1:0] preCode;
  logic [CTU_W-1:0] unitCount;

  adc_tgen_ctrl #(.CTU_W(CTU_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .preCode(preCode), .unitCount(unitCount),
    .strobes(strobes)
  );

  adc_tgen_datapath #(.CTU_W(CTU_W), .BASE_DIV(BASE_DIV), .DIV_CODES(DIV_CODES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .preCode(preCode),
    .unitCount(unitCount), .aclkEn(aclkEn), .slotStrobe(slotStrobe)
  );

endmodule

// File: rtl/adc_tgen_chk.sv
module adc_tgen_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic wrSel,
  input logic run,
  input logic aclkEn,
  input logic slotStrobe
);

  // R7: gated block produces nothing
  p_gate_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> (!aclkEn && !slotStrobe));

  // R6: slot strobe only rides on an analog-clock pulse
  p_slot_on_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    slotStrobe |-> aclkEn);

  // R4: smallest divide is 4, so a pulse never lasts two cycles
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    aclkEn |=> !aclkEn);

  // R8: a timing write restarts from zero, so the next cycle is quiet
  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (!aclkEn && !slotStrobe));

endmodule

bind adc_tgen adc_tgen_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
  .run(strobes.run), .aclkEn(aclkEn), .slotStrobe(slotStrobe)
);

// File: tb/adc_tgen_tb.sv
module adc_tgen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;
  logic        aclkEn;
  logic        slotStrobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_tgen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .aclkEn(aclkEn), .slotStrobe(slotStrobe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic sel, logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic regRead(logic sel, output logic [31:0] data);
    @(negedge clk);
    rdSel = sel;
    #1 data = rdData;
  endtask

  // Observes n cycles after a restart; index 0 is the first low phase after it.
  task automatic runWindow(string req, int div, int ctu, int n);
    int per = (ctu + 1) * 6 * div;
    int bad = 0;
    logic [31:0] actV = '0, expV = '0;
    for (int i = 0; i < n; i++) begin
      logic ea, es;
      @(negedge clk);
      ea = ((i + 1) % div) == 0;
      es = ((i + 1) % per) == 0;
      if (bad == 0 && (aclkEn !== ea || slotStrobe !== es)) begin
        bad = 1;
        actV = {i[29:0], aclkEn, slotStrobe};
        expV = {i[29:0], ea, es};
      end
    end
    check(req, actV, expV);
  endtask

  task automatic quietWindow(string req, int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (aclkEn || slotStrobe) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(1'b0, v); check("R1 timing reg", v, 32'h0);
    regRead(1'b1, v); check("R1 cfg reg", v, 32'h0);
    check("R1 outputs", {aclkEn, slotStrobe}, 2'b00);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    regWrite(1'b0, 32'hFFFF_FFFF);
    regRead(1'b0, v); check("R2 timing fields", v, 32'hE000_00FF);
    regWrite(1'b0, 32'h4000_0025);
    regRead(1'b0, v); check("R2 timing fields", v, 32'h4000_0025);
    regWrite(1'b1, 32'hFFFF_FFFE);
    regRead(1'b1, v); check("R3 cfg fields", v, 32'h8000_0002);
    regWrite(1'b1, 32'h0000_0000);
    regRead(1'b1, v); check("R3 cfg cleared", v, 32'h0);
  endtask

  task automatic testPace(string req, int code, int ctu, int div);
    regWrite(1'b1, 32'h0);
    regWrite(1'b0, {code[2:0], 21'h0, ctu[7:0]});
    regWrite(1'b1, 32'h1);
    runWindow(req, div, ctu, 2 * div * (ctu + 1) * 6 + 3);
  endtask

  task automatic testGate();
    regWrite(1'b1, 32'h0);
    regWrite(1'b0, {3'd0, 21'h0, 8'd0});
    regWrite(1'b1, 32'h1);
    repeat (10) @(negedge clk);
    regWrite(1'b1, 32'h8000_0001); quietWindow("R7 clock-down", 60);
    regWrite(1'b1, 32'h0000_0003); quietWindow("R7 power-down", 60);
    regWrite(1'b1, 32'h0000_0000); quietWindow("R7 disabled", 60);
    regWrite(1'b1, 32'h0000_0001);
    runWindow("R7 restart from zero", 4, 0, 60);
  endtask

  task automatic testCollide();
    regWrite(1'b1, 32'h0);
    regWrite(1'b0, {3'd1, 21'h0, 8'd1});
    regWrite(1'b1, 32'h1);
    repeat (37) @(negedge clk);
    do @(negedge clk); while (!aclkEn);
    wrEn = 1'b1; wrSel = 1'b0; wrData = {3'd1, 21'h0, 8'd1};
    @(posedge clk);
    #1 wrEn = 1'b0;
    runWindow("R8 write on pulse", 8, 1, 200);
    do @(negedge clk); while (!slotStrobe);
    wrEn = 1'b1; wrSel = 1'b0; wrData = {3'd0, 21'h0, 8'd2};
    @(posedge clk);
    #1 wrEn = 1'b0;
    runWindow("R8 write on slot", 4, 2, 150);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRegs();
    testPace("R4 div4", 0, 0, 4);
    testPace("R4 div16", 2, 2, 16);
    testPace("R4 div32", 3, 0, 32);
    testPace("R6 div128 ctu1", 5, 1, 128);
    testPace("R6 div8 ctu3", 1, 3, 8);
    testPace("R5 code6", 6, 0, 128);
    testPace("R5 code7", 7, 0, 128);
    testGate();
    testCollide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule